// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver

This block connects two parallel buses, called the A side and the B side, through a set of identical bit channels. Each direction has its own storage element and its own four controls: a latch enable, a data clock, an active-low clock enable and an active-low output enable. With the latch enable high, the storage element is transparent and the far-side output follows the near-side input in the same cycle. With the latch enable low, the element becomes a rising-edge register that loads only when its clock enable is asserted. Data is never inverted.

The block is built in a single system clock domain. The data clocks are sampled, and a rising edge is detected from one system cycle to the next. Pads appear as separate input, output and drive-enable signals, so no inout nets are needed. During reset and for two clocks after it is released, both drive enables are off and the stored values are zero. If both output enables are asserted at the same time, the A-to-B direction keeps its drive and the B-to-A drive is withheld.

Top module: `ubt_xcvr`

## Requirements
- R1: While a direction's latch enable is high, its far-side output equals its near-side input in the same cycle.
- R2: While latch enable is low and clock enable (active low) is 0, a data clock that is 0 at one system edge and 1 at the next loads the near-side input from that second edge. The loaded value appears at the output after that edge.
- R3: While latch enable is low and the data clock does not rise, the output keeps its stored value, even if the input changes.
- R4: While clock enable is 1, rising data clock edges are ignored and the output keeps its previous value.
- R5: When latch enable falls while the data clock is low, the output holds the input value present at the last system edge on which latch enable was high.
- R6: A drive-enable output is 1 exactly when its direction's output enable is 0, outside reset and outside the case in R9.
- R7: The B-to-A direction uses its own controls and behaves like A-to-B. Activity on one direction leaves the other direction's stored value and output unchanged.
- R8: While reset is low, both drive enables are 0 and both stored values are 0. After reset is released, the drive enables stay 0 through the first system edge and may rise from the second.
- R9: When both output enables are 0, the B-bus drive enable is 1 and the A-bus drive enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Value received from the A-side pads |
| a_out | output | WIDTH | Value to drive onto the A-side pads (B-to-A data) |
| a_oe | output | 1 | A-side pad drive enable, 1 = drive |
| b_in | input | WIDTH | Value received from the B-side pads |
| b_out | output | WIDTH | Value to drive onto the B-side pads (A-to-B data) |
| b_oe | output | 1 | B-side pad drive enable, 1 = drive |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B data clock, sampled |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A data clock, sampled |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
A corrupt stored value shows up on the far-side output as soon as the latch enable is low, one system clock after the capture that should have set it. This makes hold and gating faults visible on the next sample after a data clock pulse. An extra or missing edge detection shows up as a value loaded from the wrong cycle, so the bench changes the input right after each capture edge. A fault in the reset synchronizer or the drive-priority gating shows up directly on the drive-enable outputs, within two clocks of reset release or in the same cycle as the output enables change.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  typedef struct packed {
    logic le;
    logic dclk;
    logic ce_n;
    logic oe_n;
  } ubt_ctrl_t;

  localparam int unsigned UBT_SYNC_STAGES = 2;
endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d  = lvl_i;
    rise_o = lvl_i & ~lvl_q;
  end

  // reset to 1 so a clock already high at release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/ubt_rst_sync.sv
module ubt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign ready_o = sync_q[STAGES-1];
endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_i,
  input  ubt_ctrl_t        ctrl_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             drive_o
);
  logic             rise;
  logic             load;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;

  ubt_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ctrl_i.dclk),
    .rise_o (rise)
  );

  always_comb begin
    load    = ctrl_i.le | (rise & ~ctrl_i.ce_n);
    store_d = load ? din_i : store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_d;
  end

  assign dout_o  = ctrl_i.le ? din_i : store_q;
  assign drive_o = ready_i & ~ctrl_i.oe_n;

  // R5: transparent phase leaves the last seen input in storage
  a_r5_track: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.le |=> (store_q == $past(din_i)));

  // R2: enabled edge loads the input
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.le && ctrl_i.dclk && !$past(ctrl_i.dclk) && !ctrl_i.ce_n && $past(rst_n))
    |=> (store_q == $past(din_i)));

  // R3: no edge in latched mode, storage stable
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.le && !(ctrl_i.dclk && !$past(ctrl_i.dclk)) && $past(rst_n))
    |=> $stable(store_q));

  // R4: clock enable high blocks loading
  a_r4_ce_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.le && ctrl_i.ce_n) |=> $stable(store_q));
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_ce_n,
  input  logic             ab_oe_n,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_ce_n,
  input  logic             ba_oe_n
);
  logic      ready;
  logic      ab_drive;
  logic      ba_drive;
  ubt_ctrl_t ab_ctrl;
  ubt_ctrl_t ba_ctrl;

  ubt_rst_sync #(.STAGES(UBT_SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ready)
  );

  always_comb begin
    ab_ctrl = '{le: ab_le, dclk: ab_clk, ce_n: ab_ce_n, oe_n: ab_oe_n};
    ba_ctrl = '{le: ba_le, dclk: ba_clk, ce_n: ba_ce_n, oe_n: ba_oe_n};
  end

  ubt_path #(.WIDTH(WIDTH)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_i (ready),
    .ctrl_i  (ab_ctrl),
    .din_i   (a_in),
    .dout_o  (b_out),
    .drive_o (ab_drive)
  );

  ubt_path #(.WIDTH(WIDTH)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_i (ready),
    .ctrl_i  (ba_ctrl),
    .din_i   (b_in),
    .dout_o  (a_out),
    .drive_o (ba_drive)
  );

  // A-to-B keeps the drive when both directions request it
  assign b_oe = ab_drive;
  assign a_oe = ba_drive & ~ab_drive;

  // R8: no drive while reset is asserted
  a_r8_reset_hiz: assert property (@(posedge clk)
    !rst_n |-> (!a_oe && !b_oe));

  // R9: never both sides driven
  a_r9_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_oe, b_oe}));

  // R9: simultaneous request resolves to A-to-B
  a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && !ba_oe_n && ready) |-> (b_oe && !a_oe));
endmodule

// File: tb/ubt_xcvr_tb_top.sv
`timescale 1ns/100ps
module ubt_xcvr_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;
  logic ab_le, ab_clk, ab_ce_n, ab_oe_n;
  logic ba_le, ba_clk, ba_ce_n, ba_oe_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ubt_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n)
  );

  // behavioural reference of the truth table, sampled at the system edge
  logic [W-1:0] m_ab, m_ba;
  logic m_abp, m_bap;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; m_abp <= 1'b1; m_bap <= 1'b1;
    end else begin
      if (ab_le || (ab_clk && !m_abp && !ab_ce_n)) m_ab <= a_in;
      if (ba_le || (ba_clk && !m_bap && !ba_ce_n)) m_ba <= b_in;
      m_abp <= ab_clk;
      m_bap <= ba_clk;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle_ctrl();
    ab_le = 0; ab_clk = 0; ab_ce_n = 0; ab_oe_n = 1;
    ba_le = 0; ba_clk = 0; ba_ce_n = 0; ba_oe_n = 1;
  endtask

  task automatic t_reset();
    step(); rst_n = 0; ab_oe_n = 0; ba_oe_n = 0; a_in = 18'h2AAAA; b_in = 18'h15555;
    settle();
    chk("R8 b_oe in reset", W'(b_oe), '0);
    chk("R8 a_oe in reset", W'(a_oe), '0);
    chk("R8 b_out cleared", b_out, '0);
    chk("R8 a_out cleared", a_out, '0);
    rst_n = 1;
    step(); settle();
    chk("R8 b_oe one edge after release", W'(b_oe), '0);
    step(); settle();
    chk("R8 b_oe two edges after release", W'(b_oe), W'(1));
    ab_oe_n = 1; ba_oe_n = 1;
  endtask

  task automatic t_transparent();
    step(); ab_le = 1; a_in = 18'h1234; settle();
    chk("R1 follow 1", b_out, 18'h1234);
    a_in = 18'h3FFFF; settle();
    chk("R1 follow 2", b_out, 18'h3FFFF);
  endtask

  task automatic t_capture_hold();
    step(); ab_le = 0; ab_ce_n = 0; ab_clk = 0; a_in = 18'h0F0F0;
    step(); ab_clk = 1;
    step(); a_in = 18'h00777; settle();
    chk("R2 captured on edge", b_out, 18'h0F0F0);
    step(); ab_clk = 0; settle();
    chk("R3 hold clock low", b_out, 18'h0F0F0);
    step(); step(); settle();
    chk("R3 hold after input change", b_out, 18'h0F0F0);
  endtask

  task automatic t_ce_gate();
    step(); ab_ce_n = 1; a_in = 18'h3C3C3;
    step(); ab_clk = 1;
    step(); ab_clk = 0; settle();
    chk("R4 edge ignored", b_out, 18'h0F0F0);
    ab_ce_n = 0;
    step(); ab_clk = 1;
    step(); settle();
    chk("R2 enabled again", b_out, 18'h3C3C3);
    ab_clk = 0;
  endtask

  task automatic t_le_fall();
    step(); ab_le = 1; a_in = 18'h01ABC; settle();
    chk("R1 transparent before fall", b_out, 18'h01ABC);
    step(); ab_le = 0; a_in = 18'h22222; settle();
    chk("R5 value at fall held", b_out, 18'h01ABC);
    step(); settle();
    chk("R5 still held", b_out, 18'h01ABC);
  endtask

  task automatic t_oe();
    step(); ab_oe_n = 0; ba_oe_n = 1; settle();
    chk("R6 b_oe on", W'(b_oe), W'(1));
    chk("R6 a_oe off", W'(a_oe), '0);
    ab_oe_n = 1; ba_oe_n = 0; settle();
    chk("R6 b_oe off", W'(b_oe), '0);
    chk("R6 a_oe on", W'(a_oe), W'(1));
    ba_oe_n = 1;
  endtask

  task automatic t_ba_dir();
    step(); ba_le = 0; ba_ce_n = 0; b_in = 18'h2BEEF;
    step(); ba_clk = 1;
    step(); b_in = 18'h00001; settle();
    chk("R7 B-to-A captured", a_out, 18'h2BEEF);
    chk("R7 A-to-B untouched", b_out, 18'h01ABC);
    step(); ba_clk = 0; ba_ce_n = 1;
    step(); ba_clk = 1;
    step(); ba_clk = 0; settle();
    chk("R7 B-to-A gated", a_out, 18'h2BEEF);
    ba_le = 1; settle();
    chk("R7 B-to-A transparent, no inversion", a_out, 18'h00001);
    ba_le = 0; ba_ce_n = 0;
  endtask

  task automatic t_contention();
    step(); ab_oe_n = 0; ba_oe_n = 0; settle();
    chk("R9 B side drives", W'(b_oe), W'(1));
    chk("R9 A side withheld", W'(a_oe), '0);
    ab_oe_n = 1; settle();
    chk("R9 A side after release", W'(a_oe), W'(1));
    ba_oe_n = 1;
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      step();
      a_in = W'($urandom); b_in = W'($urandom);
      ab_le = ($urandom % 5) == 0; ba_le = ($urandom % 5) == 0;
      ab_clk = $urandom; ba_clk = $urandom;
      ab_ce_n = ($urandom % 3) == 0; ba_ce_n = ($urandom % 3) == 0;
      ab_oe_n = $urandom; ba_oe_n = $urandom;
      settle();
      chk("R2/R3/R4 random b_out", b_out, ab_le ? a_in : m_ab);
      chk("R7 random a_out", a_out, ba_le ? b_in : m_ba);
      chk("R6 random b_oe", W'(b_oe), W'(!ab_oe_n));
      chk("R9 random a_oe", W'(a_oe), W'(!ba_oe_n && ab_oe_n));
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; a_in = '0; b_in = '0;
    idle_ctrl();
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
    t_reset();
    t_transparent();
    t_capture_hold();
    t_ce_gate();
    t_le_fall();
    t_oe();
    t_ba_dir();
    t_contention();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule